// File: doc/BRIEF.md
# SPI Slave Bit Shifter with Transfer Pause

This block is the bit-level front end of an SPI serial memory slave. It oversamples the serial clock, data-in, chip-select and pause pins on a fast system clock. While the slave is selected it captures a data-in bit on every rising serial-clock edge and updates the serial output on every falling edge. Both directions run most-significant bit first. SPI modes 0 and 3 both work, because each mode takes its input on the rising edge and changes its output on the falling edge. Each received byte goes to a command layer together with a running bit position. The block takes the next transmit byte from that layer at each byte boundary.

A pause input (active low) freezes a transfer between two bits. While the block is paused, the serial clock and data-in are ignored and the output driver is disabled. When the pause is lifted, shifting continues at the bit where it stopped. Raising chip select during a pause throws away the whole transaction. Every rising edge of chip select produces an end-of-select event. The event tells the command layer whether the deselect came cleanly on a byte boundary, and whether it aborted a paused transfer.

Top module: `spi_hold_shifter`

## Requirements
- R1: While selected, a data-in bit is captured only on a rising serial-clock edge. The serial output changes only on a falling serial-clock edge or on the start of selection. Transfers work both with the clock idling low (mode 0) and with the clock idling high (mode 3).
- R2: Bytes are shifted MSB first in both directions. The first bit captured becomes bit 7 of `rx_data_o`, and `so_o` presents bit 7 of the loaded transmit byte first.
- R3: `bit_cnt_o` holds the number of bits captured so far in the current byte (0 to 7). When the eighth bit is captured, `rx_valid_o` pulses for one cycle with the whole byte on `rx_data_o`, and the count returns to 0.
- R4: A falling chip select while the serial clock is high does not capture data-in. The first capture is the first rising serial-clock edge after selection.
- R5: `tx_data_i` is loaded, and `tx_load_o` pulses, at the start of selection and at every falling serial-clock edge that occurs while `bit_cnt_o` is 0.
- R6: A pause starts when `holdb_i` is low while the serial clock is low. It ends when `holdb_i` is high while the serial clock is low. `hold_o` is 1 during a pause. A pause request made while the clock is high waits for the clock to go low, and a release made while the clock is high also waits for the clock to go low.
- R7: During a pause, serial-clock and data-in activity is ignored, `bit_cnt_o` does not change and `so_oe_o` is 0. After release, the next bit captured and the next bit driven are the ones that follow the last bit before the pause.
- R8: While chip select is high, `so_oe_o` is 0 and `bit_cnt_o` reads 0. Partial input bits are discarded, so the next selection starts a new byte.
- R9: Every rising chip select gives one `cs_end_o` pulse. `cs_aligned_o` is 1 with that pulse only if at least one byte completed, `bit_cnt_o` was 0 and the block was not paused.
- R10: A rising chip select during a pause gives `cs_end_o` together with `cs_abort_o` = 1 and `cs_aligned_o` = 0. The pause ends, and the next selection starts afresh at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data-in pin |
| csb_i | input | 1 | Chip select pin, active low |
| holdb_i | input | 1 | Pause pin, active low |
| so_o | output | 1 | Serial data-out value |
| so_oe_o | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| tx_data_i | input | DATA_W | Next byte to transmit |
| tx_load_o | output | 1 | Pulse: `tx_data_i` was captured |
| rx_data_o | output | DATA_W | Last complete received byte |
| rx_valid_o | output | 1 | Pulse: `rx_data_o` holds a new byte |
| bit_cnt_o | output | $clog2(DATA_W) | Bits captured in the current byte |
| hold_o | output | 1 | Transfer is paused |
| cs_end_o | output | 1 | Pulse on chip-select rise |
| cs_aligned_o | output | 1 | With `cs_end_o`: deselect came on a byte boundary |
| cs_abort_o | output | 1 | With `cs_end_o`: deselect came during a pause |

## Verification
The bench selects the slave while the clock is high and data-in is high. A design that took the selection edge as a sample would shift a spurious 1 into every byte after it. It requests a pause while the clock is high, and also releases one while the clock is high. A block that reacts to the pin level alone would freeze or resume one half-bit too early, and the output bit stream would then slip. Clock and data are toggled while the block is paused. A design that lost its bit position or let those edges through would return bytes that do not match the scoreboard. It would also drive the wrong transmit bits after the release. Deselecting during a pause, after a partial byte, and after whole bytes in both clock modes checks that only clean byte-boundary deselects are flagged as aligned. It also checks that an aborted transfer leaves no stale bits in the next transaction.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  typedef enum logic [1:0] {
    LINK_IDLE = 2'd0,
    LINK_RUN  = 2'd1,
    LINK_HOLD = 2'd2
  } link_state_e;

  typedef struct packed {
    logic sck;
    logic si;
    logic csb;
    logic holdb;
  } pin_bus_t;

  localparam pin_bus_t PIN_RESET = '{sck: 1'b0, si: 1'b0, csb: 1'b1, holdb: 1'b1};

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_link_ctrl.sv
module spi_link_ctrl
  import spi_shift_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic csb_s_i,
  input  logic holdb_s_i,
  input  logic at_boundary_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic flush_o,
  output logic run_o,
  output logic hold_o,
  output logic cs_end_o,
  output logic cs_aligned_o,
  output logic cs_abort_o
);

  link_state_e state_q, state_d;
  logic        sck_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LINK_IDLE: if (!csb_s_i) state_d = LINK_RUN;
      LINK_RUN: begin
        if (csb_s_i)                     state_d = LINK_IDLE;
        else if (!holdb_s_i && !sck_s_i) state_d = LINK_HOLD;
      end
      LINK_HOLD: begin
        if (csb_s_i)                    state_d = LINK_IDLE;
        else if (holdb_s_i && !sck_s_i) state_d = LINK_RUN;
      end
      default: state_d = LINK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= LINK_IDLE;
      sck_q        <= 1'b0;
      cs_end_o     <= 1'b0;
      cs_aligned_o <= 1'b0;
      cs_abort_o   <= 1'b0;
    end else begin
      state_q      <= state_d;
      sck_q        <= sck_s_i;
      cs_end_o     <= (state_q != LINK_IDLE) && csb_s_i;
      cs_aligned_o <= (state_q == LINK_RUN) && csb_s_i && at_boundary_i;
      cs_abort_o   <= (state_q == LINK_HOLD) && csb_s_i;
    end
  end

  // clock edges count only while running; sck_q tracks even when paused
  assign rise_o  = (state_q == LINK_RUN) && !csb_s_i && sck_s_i && !sck_q;
  assign fall_o  = (state_q == LINK_RUN) && !csb_s_i && !sck_s_i && sck_q;
  assign start_o = (state_q == LINK_IDLE) && !csb_s_i;
  assign flush_o = (state_q == LINK_IDLE);
  assign run_o   = (state_q == LINK_RUN);
  assign hold_o  = (state_q == LINK_HOLD);

  // R6
  hold_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(run_o)) |-> $past(!sck_s_i && !holdb_s_i));

  // R6
  hold_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(hold_o)) |-> $past(!sck_s_i && holdb_s_i));

  // R8
  desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csb_s_i && $past(csb_s_i)) |-> (!run_o && !hold_o));

  // R10
  abort_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_abort_o |-> (cs_end_o && !cs_aligned_o));

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              rise_i,
  input  logic              hold_i,
  input  logic              sd_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o,
  output logic              byte_seen_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] shreg_nxt;

  assign shreg_nxt = {shreg_q[DATA_W-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q     <= '0;
      bit_cnt_o   <= '0;
      byte_o      <= '0;
      valid_o     <= 1'b0;
      byte_seen_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (flush_i) begin
        shreg_q     <= '0;
        bit_cnt_o   <= '0;
        byte_seen_o <= 1'b0;
      end else if (rise_i) begin
        shreg_q <= shreg_nxt;
        if (bit_cnt_o == LAST_BIT) begin
          bit_cnt_o   <= '0;
          byte_o      <= shreg_nxt;
          valid_o     <= 1'b1;
          byte_seen_o <= 1'b1;
        end else begin
          bit_cnt_o <= bit_cnt_o + CNT_W'(1);
        end
      end
    end
  end

  // R3
  wrap_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((bit_cnt_o == '0) && $past(rise_i)));

  // R7
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> $stable(bit_cnt_o));

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sd_o,
  output logic              load_o
);

  logic [DATA_W-1:0] shreg_q;
  logic              load;

  // a fall at count 0 is the first drive edge of a new byte
  assign load = start_i || (fall_i && (bit_cnt_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= load;
      if (load) begin
        shreg_q <= data_i;
      end else if (fall_i) begin
        shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sd_o = shreg_q[DATA_W-1];

  // R1
  so_fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(fall_i) && !$past(start_i)) |-> $stable(sd_o));

endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter
  import spi_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              csb_i,
  input  logic              holdb_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              hold_o,
  output logic              cs_end_o,
  output logic              cs_aligned_o,
  output logic              cs_abort_o
);

  pin_bus_t pins_raw, pins_s;
  logic     rise, fall, start, flush, run, byte_seen;

  assign pins_raw = '{sck: sck_i, si: si_i, csb: csb_i, holdb: holdb_i};

  spi_pin_sync #(
    .WIDTH  ($bits(pin_bus_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RESET)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  spi_link_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sck_s_i      (pins_s.sck),
    .csb_s_i      (pins_s.csb),
    .holdb_s_i    (pins_s.holdb),
    .at_boundary_i(byte_seen && (bit_cnt_o == '0)),
    .rise_o       (rise),
    .fall_o       (fall),
    .start_o      (start),
    .flush_o      (flush),
    .run_o        (run),
    .hold_o       (hold_o),
    .cs_end_o     (cs_end_o),
    .cs_aligned_o (cs_aligned_o),
    .cs_abort_o   (cs_abort_o)
  );

  spi_rx_shift #(.DATA_W(DATA_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .rise_i     (rise),
    .hold_i     (hold_o),
    .sd_i       (pins_s.si),
    .bit_cnt_o  (bit_cnt_o),
    .byte_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .byte_seen_o(byte_seen)
  );

  spi_tx_shift #(.DATA_W(DATA_W)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .fall_i   (fall),
    .bit_cnt_i(bit_cnt_o),
    .data_i   (tx_data_i),
    .sd_o     (so_o),
    .load_o   (tx_load_o)
  );

  assign so_oe_o = run;

  // R9
  aligned_in_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_aligned_o |-> cs_end_o);

endmodule

// File: tb/test_spi_hold_shifter.sv
module test_spi_hold_shifter;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck_i = 1'b0, si_i = 1'b0, csb_i = 1'b1, holdb_i = 1'b1;
  logic [7:0] tx_data_i = 8'h00;
  logic       so_o, so_oe_o, tx_load_o, rx_valid_o, hold_o;
  logic       cs_end_o, cs_aligned_o, cs_abort_o;
  logic [7:0] rx_data_o;
  logic [2:0] bit_cnt_o;

  int         checks = 0, failures = 0;
  bit         done = 1'b0;
  logic [7:0] rx_exp[$];
  logic [7:0] tx_q[$];
  string      sb_tag = "R3";
  int         ev_cnt = 0, load_cnt = 0;
  logic       ev_aligned = 1'b0, ev_abort = 1'b0;
  int         base_ev, base_ld;

  always #4 clk = ~clk;

  spi_hold_shifter i_spi_hold_shifter (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck_i), .si_i(si_i), .csb_i(csb_i),
    .holdb_i(holdb_i), .so_o(so_o), .so_oe_o(so_oe_o), .tx_data_i(tx_data_i),
    .tx_load_o(tx_load_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .bit_cnt_o(bit_cnt_o), .hold_o(hold_o), .cs_end_o(cs_end_o),
    .cs_aligned_o(cs_aligned_o), .cs_abort_o(cs_abort_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] mosi, logic [7:0] miso, int hi, int lo,
                           bit chk, string tag);
    for (int i = hi; i >= lo; i--) begin
      sck_i = 1'b0;
      si_i  = mosi[i];
      half();
      if (chk) begin
        check(tag, "so_oe", 32'(so_oe_o), 32'd1);
        check(tag, "so bit", 32'(so_o), 32'(miso[i]));
      end
      sck_i = 1'b1;
      half();
    end
  endtask

  task automatic send_byte(logic [7:0] mosi, logic [7:0] miso, bit chk, string tag);
    rx_exp.push_back(mosi);
    send_bits(mosi, miso, 7, 0, chk, tag);
  endtask

  // scoreboard monitor and transmit-side command layer
  always @(negedge clk) begin
    if (rx_valid_o) begin
      checks++;
      if (rx_exp.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected byte actual=%0h expected=none", sb_tag, rx_data_o);
      end else begin
        logic [7:0] e;
        e = rx_exp.pop_front();
        if (rx_data_o !== e) begin
          failures++;
          $display("FAIL %s rx byte actual=%0h expected=%0h", sb_tag, rx_data_o, e);
        end
      end
    end
    if (tx_load_o) load_cnt++;
    if (cs_end_o) begin
      ev_cnt++;
      ev_aligned = cs_aligned_o;
      ev_abort   = cs_abort_o;
    end
    if (csb_i) begin
      tx_data_i = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    end else if (rx_valid_o) begin
      if (tx_q.size() > 0) void'(tx_q.pop_front());
      tx_data_i = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (HALF * 100000 / 8) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R8", "reset so_oe", 32'(so_oe_o), 32'd0);
    check("R3", "reset bit_cnt", 32'(bit_cnt_o), 32'd0);
    check("R6", "reset hold", 32'(hold_o), 32'd0);
    rst_ni = 1'b1;
    half();

    // mode 0, three bytes
    tx_q = '{8'h96, 8'h0F, 8'h81};
    half();
    base_ev = ev_cnt; base_ld = load_cnt;
    csb_i = 1'b0;
    half();
    rx_exp.push_back(8'hA5);
    send_bits(8'hA5, 8'h96, 7, 5, 1'b1, "R2");
    check("R3", "bit_cnt mid", 32'(bit_cnt_o), 32'd3);
    send_bits(8'hA5, 8'h96, 4, 0, 1'b1, "R2");
    check("R3", "bit_cnt wrap", 32'(bit_cnt_o), 32'd0);
    send_byte(8'h3C, 8'h0F, 1'b1, "R2");
    send_byte(8'hF0, 8'h81, 1'b1, "R2");
    sck_i = 1'b0;
    half();
    csb_i = 1'b1;
    half();
    check("R9", "event count", 32'(ev_cnt - base_ev), 32'd1);
    check("R9", "aligned", 32'(ev_aligned), 32'd1);
    check("R8", "so_oe deselected", 32'(so_oe_o), 32'd0);
    check("R5", "mode0 loads", 32'(load_cnt - base_ld), 32'd4);
    check("R3", "scoreboard drained", 32'(rx_exp.size()), 32'd0);

    // mode 3, two bytes
    sck_i = 1'b1;
    tx_q = '{8'hE7, 8'h18};
    half();
    base_ld = load_cnt;
    csb_i = 1'b0;
    half();
    send_byte(8'h6B, 8'hE7, 1'b1, "R1");
    send_byte(8'hD2, 8'h18, 1'b1, "R1");
    csb_i = 1'b1;
    half();
    check("R9", "mode3 aligned", 32'(ev_aligned), 32'd1);
    check("R5", "mode3 loads", 32'(load_cnt - base_ld), 32'd3);

    // selection while clock and data are high
    sb_tag = "R4";
    sck_i = 1'b1; si_i = 1'b1;
    tx_q = '{8'h00};
    half();
    csb_i = 1'b0;
    half(); half();
    check("R4", "no sample on select", 32'(bit_cnt_o), 32'd0);
    sck_i = 1'b0;
    half();
    send_byte(8'h5A, 8'h00, 1'b0, "R4");
    send_bits(8'hFF, 8'h00, 7, 5, 1'b0, "R8");
    sck_i = 1'b0;
    half();
    csb_i = 1'b1;
    half();
    check("R9", "partial not aligned", 32'(ev_aligned), 32'd0);
    check("R8", "bit_cnt cleared", 32'(bit_cnt_o), 32'd0);
    check("R4", "scoreboard drained", 32'(rx_exp.size()), 32'd0);

    // pause mid-byte
    sb_tag = "R7";
    sck_i = 1'b0;
    tx_q = '{8'hB4, 8'hCC};
    half();
    csb_i = 1'b0;
    half();
    rx_exp.push_back(8'hC3);
    send_bits(8'hC3, 8'hB4, 7, 4, 1'b1, "R2");
    sck_i = 1'b0;
    half();
    holdb_i = 1'b0;
    half();
    check("R6", "paused", 32'(hold_o), 32'd1);
    check("R7", "so_oe paused", 32'(so_oe_o), 32'd0);
    for (int k = 0; k < 3; k++) begin
      si_i = ~si_i; sck_i = 1'b1; half();
      sck_i = 1'b0; half();
    end
    check("R7", "bit_cnt frozen", 32'(bit_cnt_o), 32'd4);
    holdb_i = 1'b1;
    half();
    check("R6", "released", 32'(hold_o), 32'd0);
    check("R7", "so_oe resumed", 32'(so_oe_o), 32'd1);
    send_bits(8'hC3, 8'hB4, 3, 0, 1'b1, "R7");
    // pause requested and released while the clock is high
    rx_exp.push_back(8'h3E);
    send_bits(8'h3E, 8'hCC, 7, 7, 1'b1, "R2");
    holdb_i = 1'b0;
    half();
    check("R6", "no pause with sck high", 32'(hold_o), 32'd0);
    sck_i = 1'b0;
    half();
    check("R6", "pause on sck low", 32'(hold_o), 32'd1);
    sck_i = 1'b1;
    half();
    holdb_i = 1'b1;
    half();
    check("R6", "no release with sck high", 32'(hold_o), 32'd1);
    sck_i = 1'b0;
    half();
    check("R6", "release on sck low", 32'(hold_o), 32'd0);
    check("R7", "bit_cnt after resume", 32'(bit_cnt_o), 32'd1);
    send_bits(8'h3E, 8'hCC, 6, 0, 1'b1, "R7");
    sck_i = 1'b0;
    half();
    csb_i = 1'b1;
    half();
    check("R9", "aligned after pauses", 32'(ev_aligned), 32'd1);
    check("R7", "scoreboard drained", 32'(rx_exp.size()), 32'd0);

    // deselect during a pause
    sb_tag = "R10";
    tx_q = '{8'h5F, 8'hA0};
    half();
    csb_i = 1'b0;
    half();
    send_bits(8'h96, 8'h5F, 7, 3, 1'b0, "R10");
    sck_i = 1'b0;
    half();
    holdb_i = 1'b0;
    half();
    base_ev = ev_cnt;
    csb_i = 1'b1;
    half();
    check("R10", "abort event", 32'(ev_cnt - base_ev), 32'd1);
    check("R10", "abort flag", 32'(ev_abort), 32'd1);
    check("R10", "abort not aligned", 32'(ev_aligned), 32'd0);
    check("R10", "pause cleared", 32'(hold_o), 32'd0);
    check("R8", "so_oe after abort", 32'(so_oe_o), 32'd0);
    holdb_i = 1'b1;
    tx_q.delete();
    tx_q.push_back(8'h77);
    half();
    csb_i = 1'b0;
    half();
    check("R10", "fresh bit_cnt", 32'(bit_cnt_o), 32'd0);
    send_byte(8'h69, 8'h77, 1'b1, "R10");
    sck_i = 1'b0;
    half();
    csb_i = 1'b1;
    half();
    check("R9", "aligned after abort", 32'(ev_aligned), 32'd1);
    check("R10", "no abort flag", 32'(ev_abort), 32'd0);
    check("R10", "scoreboard drained", 32'(rx_exp.size()), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule